// File: doc/BRIEF.md
# AUX Channel Transaction Sequencer

This block carries out one complete request/reply exchange on a display AUX side channel for a host. The host gives a 4-bit request code, a 20-bit target address, a payload length, a read/write selector and, for writes, up to 16 payload bytes. The sequencer builds the request header, lays the message out as five 32-bit big-endian data words and starts the link-side transceiver. It then waits for the completion pulse, clears the completion flags, retries on errors and, at the end, checks the reply length and turns the reply bytes into a result for the host. Line coding is not part of this block. The link is seen only as a start strobe, a busy flag and a completion pulse that carries timeout and receive-error qualifiers.

The controller is a single state machine with seven states. `ST_IDLE` goes to `ST_PROBE` on `req_start`. `ST_PROBE` samples the busy flag on each cycle. When the flag is clear it goes to `ST_SEND`, or to `ST_FINISH` if the request is over size. When the probe budget runs out it goes to `ST_FINISH`. `ST_SEND` strobes the link and moves to `ST_WAIT`. `ST_WAIT` goes to `ST_CLEAR` when the completion pulse arrives. From `ST_CLEAR` the machine goes to `ST_SEND` after a timeout, to `ST_BACKOFF` after a receive error, or to `ST_FINISH` when it succeeds or runs out of attempts. `ST_BACKOFF` returns to `ST_SEND` when its timer expires. `ST_FINISH` pulses the result and returns to `ST_IDLE`.

Top module: `aux_xact_seq`

## Requirements
- R1: The header bytes are built as follows. Byte 0 is `{req_cmd, req_addr[19:16]}`, byte 1 is `req_addr[15:8]` and byte 2 is `req_addr[7:0]`. Byte 3 is `req_len-1` when `req_len` is not zero. `link_tx_len` is 3 when `req_len` is 0, 4 for a read, and `req_len+4` for a write.
- R2: Message byte b sits in word b/4 of `link_tx_words`, at bits `[32*(b/4)+31-8*(b%4) -: 8]`, so the first byte of each word is the most significant. Write payload byte k (`req_wdata[8k+:8]`) is message byte 4+k. All bytes that are not used are zero.
- R3: After `req_start` the busy flag is sampled on up to 3 consecutive cycles. If all three samples see it set, the result is BUSY (code 1) and `link_go` never pulses. If any of the three samples sees it clear, the transfer goes ahead.
- R4: A write with `req_len` > 16, or a read with `req_len` > 19, ends with TOO_BIG (code 4) and no `link_go`.
- R5: After a completion flagged as a timeout, `link_go` for the next attempt comes exactly 1 cycle after `link_clr`. A timeout takes priority over a receive error.
- R6: After a completion flagged as a receive error, `link_go` for the next attempt comes exactly BACKOFF_CYC+1 cycles after `link_clr`.
- R7: A request gets at most 5 `link_go` pulses. If every attempt fails, the result comes from the last attempt: TIMEOUT (code 2) or RX_ERROR (code 3).
- R8: `link_clr` is a single-cycle pulse in the cycle that follows each completion pulse the sequencer accepts.
- R9: An error-free completion whose `link_rx_len` is 0 or greater than 20 ends with BUSY (code 1).
- R10: In a good reply, `res_reply` is the upper nibble of reply byte 0. Reply bytes are unpacked with the same positions as in R2. For a read, `res_count` is `min(link_rx_len, req_len+1)-1`, and `res_rdata[8k+:8]` holds reply byte k+1 for k < `res_count` and zero above that.
- R11: For a good write reply, let e = `min(link_rx_len, 2)`. `res_count` is `min(reply byte 1, req_len)` when e is 2, and `req_len` otherwise. `res_rdata` is zero.
- R12: `res_valid` is a single-cycle pulse. A success carries code OK (0). Any other code carries zero count, zero reply and zero data. After reset, `res_valid`, `link_go` and `link_clr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_start | input | 1 | Starts a request (sampled in idle) |
| req_read | input | 1 | 1 = read request, 0 = write request |
| req_cmd | input | 4 | Request code |
| req_addr | input | 20 | Target address |
| req_len | input | 5 | Payload length in bytes |
| req_wdata | input | 128 | Write payload, byte k at [8k+:8] |
| link_busy | input | 1 | Link channel still busy from earlier activity |
| link_go | output | 1 | Single-cycle start of one attempt |
| link_tx_words | output | 160 | Five packed message words, word w at [32w+:32] |
| link_tx_len | output | 5 | Number of message bytes to send |
| link_done | input | 1 | Completion pulse of an attempt |
| link_timeout | input | 1 | Qualifies completion: reply timed out |
| link_rxerr | input | 1 | Qualifies completion: reply received with error |
| link_rx_len | input | 5 | Number of reply bytes reported |
| link_rx_words | input | 160 | Packed reply words, same layout as transmit |
| link_clr | output | 1 | Clears the link's completion and error flags |
| res_valid | output | 1 | Single-cycle result pulse |
| res_code | output | 3 | 0 OK, 1 BUSY, 2 TIMEOUT, 3 RX_ERROR, 4 TOO_BIG |
| res_reply | output | 4 | Reply code of a good reply |
| res_count | output | 5 | Bytes read or bytes written |
| res_rdata | output | 152 | Read data, byte k at [8k+:8] |

## Verification
The assertions assume that `req_start` comes only while the sequencer is idle, that is, after the previous `res_valid` and before the next request is launched. They also assume that `link_done` is a one-cycle pulse that the link gives only after a `link_go`. The attempt counter in the checker and the clear-after-completion property depend on these two points. The bench keeps to them. It issues each request only after the previous result has been collected, and its link model answers each `link_go` with exactly one completion pulse a few cycles later, with reply length and data held steady across the whole transaction.

// File: rtl/aux_seq_pkg.sv
package aux_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROBE,
        ST_SEND,
        ST_WAIT,
        ST_CLEAR,
        ST_BACKOFF,
        ST_FINISH
    } seq_state_e;

    typedef enum logic [2:0] {
        RES_OK      = 3'd0,
        RES_BUSY    = 3'd1,
        RES_TIMEOUT = 3'd2,
        RES_RXERR   = 3'd3,
        RES_TOOBIG  = 3'd4
    } res_code_e;

endpackage

// File: rtl/aux_msg_pack.sv
module aux_msg_pack #(
    parameter  int MSG_BYTES = 20,
    localparam int LEN_W     = $clog2(MSG_BYTES + 1),
    localparam int PAY_BYTES = MSG_BYTES - 4,
    localparam int WORDS     = MSG_BYTES / 4
) (
    input  logic [3:0]             cmd,
    input  logic [19:0]            addr,
    input  logic [LEN_W-1:0]       len,
    input  logic                   is_read,
    input  logic [8*PAY_BYTES-1:0] wdata,
    output logic [32*WORDS-1:0]    words,
    output logic [LEN_W-1:0]       tx_len,
    output logic                   too_big
);
    localparam logic [LEN_W-1:0] PAY_MAX = LEN_W'(PAY_BYTES);
    localparam logic [LEN_W-1:0] RD_MAX  = LEN_W'(MSG_BYTES - 1);
    localparam logic [LEN_W-1:0] HDR_LEN = LEN_W'(4);
    localparam logic [LEN_W-1:0] ADR_LEN = LEN_W'(3);

    logic [7:0] mb [MSG_BYTES];

    // header then payload, byte-addressed
    always_comb begin
        mb[0] = {cmd, addr[19:16]};
        mb[1] = addr[15:8];
        mb[2] = addr[7:0];
        mb[3] = (len != '0) ? 8'(len - LEN_W'(1)) : 8'h00;
        for (int k = 0; k < PAY_BYTES; k++) begin
            mb[4+k] = (!is_read && (LEN_W'(k) < len)) ? wdata[8*k +: 8] : 8'h00;
        end
    end

    // big-endian placement inside each word
    for (genvar w = 0; w < WORDS; w++) begin : g_word
        for (genvar i = 0; i < 4; i++) begin : g_byte
            assign words[32*w + 31 - 8*i -: 8] = mb[4*w + i];
        end
    end

    assign too_big = is_read ? (len > RD_MAX) : (len > PAY_MAX);
    assign tx_len  = (len == '0) ? ADR_LEN : (is_read ? HDR_LEN : len + HDR_LEN);

endmodule

// File: rtl/aux_reply_unpack.sv
module aux_reply_unpack #(
    parameter  int MSG_BYTES = 20,
    localparam int LEN_W     = $clog2(MSG_BYTES + 1),
    localparam int WORDS     = MSG_BYTES / 4
) (
    input  logic                     is_read,
    input  logic [LEN_W-1:0]         len,
    input  logic [LEN_W-1:0]         rx_len,
    input  logic [32*WORDS-1:0]      rx_words,
    output logic                     len_bad,
    output logic [3:0]               reply,
    output logic [LEN_W-1:0]         count,
    output logic [8*(MSG_BYTES-1)-1:0] rdata
);
    localparam logic [LEN_W-1:0] MSG_MAX = LEN_W'(MSG_BYTES);

    logic [7:0]       rb [MSG_BYTES];
    logic [LEN_W-1:0] want;
    logic [LEN_W-1:0] eff;
    logic             unused_low;

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        for (genvar i = 0; i < 4; i++) begin : g_byte
            assign rb[4*w + i] = rx_words[32*w + 31 - 8*i -: 8];
        end
    end

    assign unused_low = ^rb[0][3:0];

    always_comb begin
        want    = is_read ? len + LEN_W'(1) : LEN_W'(2);
        eff     = (rx_len < want) ? rx_len : want;
        len_bad = (rx_len == '0) || (rx_len > MSG_MAX);
        reply   = rb[0][7:4];
        rdata   = '0;
        count   = len;
        if (is_read) begin
            count = (eff == '0) ? '0 : eff - LEN_W'(1);
            for (int k = 0; k < MSG_BYTES - 1; k++) begin
                if (LEN_W'(k) < count) rdata[8*k +: 8] = rb[k+1];
            end
        end else if (eff >= LEN_W'(2)) begin
            count = (rb[1] > 8'(len)) ? len : rb[1][LEN_W-1:0];
        end
    end

endmodule

// File: rtl/aux_backoff_timer.sv
module aux_backoff_timer #(
    parameter  int CYC = 45000,
    localparam int CW  = $clog2(CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt_q <= '0;
        else if (run) cnt_q <= cnt_q + CW'(1);
        else          cnt_q <= '0;
    end

    assign expire = run && (cnt_q == CW'(CYC - 1));

endmodule

// File: rtl/aux_xact_seq.sv
module aux_xact_seq
    import aux_seq_pkg::*;
#(
    parameter  int MSG_BYTES   = 20,
    parameter  int MAX_TRIES   = 5,
    parameter  int BUSY_PROBES = 3,
    parameter  int BACKOFF_CYC = 45000,
    localparam int LEN_W       = $clog2(MSG_BYTES + 1),
    localparam int WORDS       = MSG_BYTES / 4,
    localparam int PAY_BYTES   = MSG_BYTES - 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_start,
    input  logic                       req_read,
    input  logic [3:0]                 req_cmd,
    input  logic [19:0]                req_addr,
    input  logic [LEN_W-1:0]           req_len,
    input  logic [8*PAY_BYTES-1:0]     req_wdata,
    input  logic                       link_busy,
    output logic                       link_go,
    output logic [32*WORDS-1:0]        link_tx_words,
    output logic [LEN_W-1:0]           link_tx_len,
    input  logic                       link_done,
    input  logic                       link_timeout,
    input  logic                       link_rxerr,
    input  logic [LEN_W-1:0]           link_rx_len,
    input  logic [32*WORDS-1:0]        link_rx_words,
    output logic                       link_clr,
    output logic                       res_valid,
    output logic [2:0]                 res_code,
    output logic [3:0]                 res_reply,
    output logic [LEN_W-1:0]           res_count,
    output logic [8*(MSG_BYTES-1)-1:0] res_rdata
);
    localparam int TRY_W = $clog2(MAX_TRIES + 1);
    localparam int PRB_W = $clog2(BUSY_PROBES + 1);

    seq_state_e state_q, state_d;
    res_code_e  verdict;

    // captured request
    logic                     rd_q;
    logic [3:0]               cmd_q;
    logic [19:0]              addr_q;
    logic [LEN_W-1:0]         len_q;
    logic [8*PAY_BYTES-1:0]   wdata_q;
    // sequencing
    logic [PRB_W-1:0]         probe_q;
    logic [TRY_W-1:0]         tries_q;
    // last completion
    logic                     to_q, rx_q;
    logic [LEN_W-1:0]         rxlen_q;
    logic [32*WORDS-1:0]      rxw_q;
    // result
    res_code_e                code_q;
    logic [3:0]               reply_q;
    logic [LEN_W-1:0]         count_q;
    logic [8*(MSG_BYTES-1)-1:0] rdata_q;

    logic                     too_big;
    logic                     len_bad;
    logic [3:0]               up_reply;
    logic [LEN_W-1:0]         up_count;
    logic [8*(MSG_BYTES-1)-1:0] up_rdata;
    logic                     bo_expire;
    logic                     in_wait;

    aux_msg_pack #(.MSG_BYTES(MSG_BYTES)) u_pack (
        .cmd     (cmd_q),
        .addr    (addr_q),
        .len     (len_q),
        .is_read (rd_q),
        .wdata   (wdata_q),
        .words   (link_tx_words),
        .tx_len  (link_tx_len),
        .too_big (too_big)
    );

    aux_reply_unpack #(.MSG_BYTES(MSG_BYTES)) u_unpack (
        .is_read  (rd_q),
        .len      (len_q),
        .rx_len   (rxlen_q),
        .rx_words (rxw_q),
        .len_bad  (len_bad),
        .reply    (up_reply),
        .count    (up_count),
        .rdata    (up_rdata)
    );

    aux_backoff_timer #(.CYC(BACKOFF_CYC)) u_backoff (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state_q == ST_BACKOFF),
        .expire (bo_expire)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions and verdict
    always_comb begin
        state_d = state_q;
        verdict = RES_OK;
        unique case (state_q)
            ST_IDLE: begin
                if (req_start) state_d = ST_PROBE;
            end
            ST_PROBE: begin
                if (!link_busy) begin
                    if (too_big) begin
                        state_d = ST_FINISH;
                        verdict = RES_TOOBIG;
                    end else begin
                        state_d = ST_SEND;
                    end
                end else if (probe_q == PRB_W'(BUSY_PROBES - 1)) begin
                    state_d = ST_FINISH;
                    verdict = RES_BUSY;
                end
            end
            ST_SEND: state_d = ST_WAIT;
            ST_WAIT: begin
                if (link_done) state_d = ST_CLEAR;
            end
            ST_CLEAR: begin
                if (to_q) begin
                    verdict = RES_TIMEOUT;
                    state_d = (tries_q < TRY_W'(MAX_TRIES)) ? ST_SEND : ST_FINISH;
                end else if (rx_q) begin
                    verdict = RES_RXERR;
                    state_d = (tries_q < TRY_W'(MAX_TRIES)) ? ST_BACKOFF : ST_FINISH;
                end else begin
                    verdict = len_bad ? RES_BUSY : RES_OK;
                    state_d = ST_FINISH;
                end
            end
            ST_BACKOFF: begin
                if (bo_expire) state_d = ST_SEND;
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q    <= 1'b0;
            cmd_q   <= '0;
            addr_q  <= '0;
            len_q   <= '0;
            wdata_q <= '0;
            probe_q <= '0;
            tries_q <= '0;
            to_q    <= 1'b0;
            rx_q    <= 1'b0;
            rxlen_q <= '0;
            rxw_q   <= '0;
            code_q  <= RES_OK;
            reply_q <= '0;
            count_q <= '0;
            rdata_q <= '0;
        end else begin
            if (state_q == ST_IDLE && req_start) begin
                rd_q    <= req_read;
                cmd_q   <= req_cmd;
                addr_q  <= req_addr;
                len_q   <= req_len;
                wdata_q <= req_wdata;
            end
            probe_q <= (state_q == ST_PROBE) ? probe_q + PRB_W'(1) : '0;
            if (state_q == ST_IDLE)      tries_q <= '0;
            else if (state_q == ST_SEND) tries_q <= tries_q + TRY_W'(1);
            if (state_q == ST_WAIT && link_done) begin
                to_q    <= link_timeout;
                rx_q    <= link_rxerr;
                rxlen_q <= link_rx_len;
                rxw_q   <= link_rx_words;
            end
            if (state_d == ST_FINISH && state_q != ST_FINISH) begin
                code_q <= verdict;
                if (verdict == RES_OK) begin
                    reply_q <= up_reply;
                    count_q <= up_count;
                    rdata_q <= up_rdata;
                end else begin
                    reply_q <= '0;
                    count_q <= '0;
                    rdata_q <= '0;
                end
            end
        end
    end

    // outputs
    always_comb begin
        link_go   = (state_q == ST_SEND);
        link_clr  = (state_q == ST_CLEAR);
        in_wait   = (state_q == ST_WAIT);
        res_valid = (state_q == ST_FINISH);
        res_code  = code_q;
        res_reply = reply_q;
        res_count = count_q;
        res_rdata = rdata_q;
    end

endmodule

// File: rtl/aux_seq_checker.sv
module aux_seq_checker #(
    parameter  int MSG_BYTES = 20,
    parameter  int MAX_TRIES = 5,
    localparam int LEN_W     = $clog2(MSG_BYTES + 1),
    localparam int GC_W      = $clog2(MAX_TRIES + 2)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             link_go,
    input logic             link_clr,
    input logic             link_done,
    input logic             in_wait,
    input logic             res_valid,
    input logic [2:0]       res_code,
    input logic [3:0]       res_reply,
    input logic [LEN_W-1:0] res_count
);
    logic [GC_W-1:0] go_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         go_cnt <= '0;
        else if (res_valid) go_cnt <= '0;
        else if (link_go)   go_cnt <= go_cnt + GC_W'(1);
    end

    AST_TRY_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
        link_go |-> (go_cnt < GC_W'(MAX_TRIES))); // R7

    AST_CLR_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_wait && link_done) |=> link_clr); // R8

    AST_CLR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        link_clr |=> !link_clr); // R8

    AST_GO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        link_go |=> !link_go); // R5

    AST_RES_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid); // R12

    AST_FAIL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_code != 3'd0) |-> (res_count == '0 && res_reply == 4'd0)); // R12

    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_count <= LEN_W'(MSG_BYTES - 1))); // R10

endmodule

bind aux_xact_seq aux_seq_checker #(
    .MSG_BYTES (MSG_BYTES),
    .MAX_TRIES (MAX_TRIES)
) u_seq_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .link_go   (link_go),
    .link_clr  (link_clr),
    .link_done (link_done),
    .in_wait   (in_wait),
    .res_valid (res_valid),
    .res_code  (res_code),
    .res_reply (res_reply),
    .res_count (res_count)
);

// File: tb/test_aux_xact_seq.sv
module test_aux_xact_seq;
    localparam int BO  = 12;
    localparam int LAT = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_start = 1'b0;
    logic         req_read = 1'b0;
    logic [3:0]   req_cmd = '0;
    logic [19:0]  req_addr = '0;
    logic [4:0]   req_len = '0;
    logic [127:0] req_wdata = '0;
    logic         link_busy = 1'b0;
    logic         link_go;
    logic [159:0] link_tx_words;
    logic [4:0]   link_tx_len;
    logic         link_done = 1'b0;
    logic         link_timeout = 1'b0;
    logic         link_rxerr = 1'b0;
    logic [4:0]   link_rx_len = '0;
    logic [159:0] link_rx_words = '0;
    logic         link_clr;
    logic         res_valid;
    logic [2:0]   res_code;
    logic [3:0]   res_reply;
    logic [4:0]   res_count;
    logic [151:0] res_rdata;

    aux_xact_seq #(.BACKOFF_CYC(BO)) i_aux_xact_seq (
        .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_read(req_read),
        .req_cmd(req_cmd), .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
        .link_busy(link_busy), .link_go(link_go), .link_tx_words(link_tx_words),
        .link_tx_len(link_tx_len), .link_done(link_done), .link_timeout(link_timeout),
        .link_rxerr(link_rxerr), .link_rx_len(link_rx_len), .link_rx_words(link_rx_words),
        .link_clr(link_clr), .res_valid(res_valid), .res_code(res_code),
        .res_reply(res_reply), .res_count(res_count), .res_rdata(res_rdata)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    always @(posedge clk) cyc = cyc + 1;

    // link model state
    int outc [8];
    int gap [8];
    int go_n = 0;
    int clr_n = 0;
    int last_clr = 0;
    logic [159:0] first_words = '0;
    logic [4:0]   first_len = '0;
    logic [7:0]   rxb [20];

    // captured result
    logic [2:0]   g_code;
    logic [3:0]   g_reply;
    logic [4:0]   g_count;
    logic [151:0] g_rdata;

    task automatic chk(input string rq, input string what,
                       input logic [159:0] act, input logic [159:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // responder: answers each go with one completion
    initial begin
        int oc;
        forever begin
            @(negedge clk);
            if (link_clr) begin clr_n++; last_clr = cyc; end
            if (link_go) begin
                if (go_n < 8) gap[go_n] = cyc - last_clr;
                if (go_n == 0) begin
                    first_words = link_tx_words;
                    first_len   = link_tx_len;
                end
                oc = outc[(go_n < 8) ? go_n : 7];
                go_n++;
                repeat (LAT) @(negedge clk);
                link_done    = 1'b1;
                link_timeout = (oc == 1 || oc == 3);
                link_rxerr   = (oc == 2 || oc == 3);
                @(negedge clk);
                link_done    = 1'b0;
                link_timeout = 1'b0;
                link_rxerr   = 1'b0;
                if (link_clr) begin clr_n++; last_clr = cyc; end
            end
        end
    end

    function automatic logic [159:0] exp_pack(logic rd, logic [3:0] c, logic [19:0] a,
                                              int n, logic [127:0] wd);
        logic [7:0]   bt [20];
        logic [159:0] w;
        for (int b = 0; b < 20; b++) bt[b] = 8'h00;
        bt[0] = {c, a[19:16]};
        bt[1] = a[15:8];
        bt[2] = a[7:0];
        if (n > 0) bt[3] = 8'(n - 1);
        if (!rd) for (int k = 0; k < n && k < 16; k++) bt[4+k] = wd[8*k +: 8];
        w = '0;
        for (int b = 0; b < 20; b++) w[32*(b/4) + 31 - 8*(b%4) -: 8] = bt[b];
        return w;
    endfunction

    function automatic int exp_txlen(logic rd, int n);
        if (n == 0) return 3;
        return rd ? 4 : n + 4;
    endfunction

    task automatic load_rx(input int rlen);
        link_rx_len = 5'(rlen);
        link_rx_words = '0;
        for (int b = 0; b < 20; b++) link_rx_words[32*(b/4) + 31 - 8*(b%4) -: 8] = rxb[b];
    endtask

    task automatic set_outc(input int a0, input int a1, input int a2, input int a3, input int a4);
        outc[0] = a0; outc[1] = a1; outc[2] = a2; outc[3] = a3; outc[4] = a4;
        outc[5] = 0; outc[6] = 0; outc[7] = 0;
    endtask

    task automatic run_txn(input logic rd, input logic [3:0] c, input logic [19:0] a,
                           input int n, input logic [127:0] wd);
        int waited;
        go_n = 0;
        clr_n = 0;
        @(negedge clk);
        req_read = rd; req_cmd = c; req_addr = a; req_len = 5'(n); req_wdata = wd;
        req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        waited = 0;
        while (!res_valid && waited < 5000) begin
            @(negedge clk);
            waited++;
        end
        if (!res_valid) begin
            n_chk++; n_err++;
            $display("FAIL R12 no result pulse: actual=0 expected=1");
        end
        g_code = res_code; g_reply = res_reply; g_count = res_count; g_rdata = res_rdata;
        @(negedge clk);
        chk("R12", "pulse width", 160'(res_valid), 160'(0));
    endtask

    // expected outcome of a completed reply (no link errors)
    task automatic check_reply(input string rq, input logic rd, input int n, input int rlen);
        int want, eff, cnt;
        logic [151:0] ed;
        ed = '0;
        if (rlen == 0 || rlen > 20) begin
            chk("R9", "code", 160'(g_code), 160'(1));
            chk("R9", "count", 160'(g_count), 160'(0));
            return;
        end
        want = rd ? n + 1 : 2;
        eff  = (rlen < want) ? rlen : want;
        if (rd) begin
            cnt = eff - 1;
            for (int k = 0; k < cnt; k++) ed[8*k +: 8] = rxb[k+1];
        end else begin
            cnt = (eff >= 2) ? ((int'(rxb[1]) < n) ? int'(rxb[1]) : n) : n;
        end
        chk(rq, "code", 160'(g_code), 160'(0));
        chk(rq, "reply", 160'(g_reply), 160'(rxb[0][7:4]));
        chk(rq, "count", 160'(g_count), 160'(cnt));
        chk(rq, "rdata", 160'(g_rdata), 160'(ed));
    endtask

    initial begin
        logic [127:0] wd;
        void'($urandom(32'd2024));
        for (int b = 0; b < 20; b++) rxb[b] = 8'(b * 17 + 3);
        set_outc(0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk("R12", "reset res_valid", 160'(res_valid), 160'(0));
        chk("R12", "reset link_go", 160'(link_go), 160'(0));
        chk("R12", "reset link_clr", 160'(link_clr), 160'(0));

        // R1 R2 R11: write of 8 bytes, plain ack (reply length 1)
        wd = 128'h00112233_44556677_8899aabb_ccddeeff;
        load_rx(1);
        run_txn(1'b0, 4'h8, 20'hA_BC12, 8, wd);
        chk("R1", "tx words", first_words, exp_pack(1'b0, 4'h8, 20'hA_BC12, 8, wd));
        chk("R2", "tx len", 160'(first_len), 160'(exp_txlen(1'b0, 8)));
        check_reply("R11", 1'b0, 8, 1);

        // R11 short write count and clamp
        rxb[1] = 8'd3; load_rx(2);
        run_txn(1'b0, 4'h8, 20'h00100, 8, wd);
        check_reply("R11", 1'b0, 8, 2);
        rxb[1] = 8'd200; load_rx(2);
        run_txn(1'b0, 4'h8, 20'h00100, 8, wd);
        chk("R11", "clamped count", 160'(g_count), 160'(8));

        // R1 address-only read
        load_rx(1);
        run_txn(1'b1, 4'h9, 20'hF_0F0F, 0, '0);
        chk("R1", "tx len addr-only", 160'(first_len), 160'(3));
        chk("R1", "tx words addr-only", first_words, exp_pack(1'b1, 4'h9, 20'hF_0F0F, 0, '0));
        check_reply("R10", 1'b1, 0, 1);

        // R10 read at upper legal length
        load_rx(20);
        run_txn(1'b1, 4'h9, 20'h12345, 19, '0);
        chk("R10", "tx len read", 160'(first_len), 160'(4));
        check_reply("R10", 1'b1, 19, 20);

        // R4 oversize requests
        run_txn(1'b0, 4'h8, 20'h1, 17, wd);
        chk("R4", "write too big", 160'(g_code), 160'(4));
        chk("R4", "no go", 160'(go_n), 160'(0));
        run_txn(1'b1, 4'h9, 20'h1, 20, '0);
        chk("R4", "read too big", 160'(g_code), 160'(4));
        run_txn(1'b0, 4'h8, 20'h1, 16, wd);
        chk("R4", "write 16 allowed", 160'(go_n), 160'(1));

        // R3 busy throughout
        link_busy = 1'b1;
        run_txn(1'b1, 4'h9, 20'h2, 1, '0);
        chk("R3", "busy code", 160'(g_code), 160'(1));
        chk("R3", "busy no go", 160'(go_n), 160'(0));
        // R3 busy clears on the last sample
        fork
            run_txn(1'b1, 4'h9, 20'h2, 1, '0);
            begin repeat (4) @(negedge clk); link_busy = 1'b0; end
        join
        chk("R3", "late free go", 160'(go_n), 160'(1));
        chk("R3", "late free code", 160'(g_code), 160'(0));
        link_busy = 1'b0;

        // R5 R7 all timeouts
        set_outc(1, 1, 1, 1, 1);
        run_txn(1'b1, 4'h9, 20'h3, 2, '0);
        chk("R7", "timeout code", 160'(g_code), 160'(2));
        chk("R7", "attempts", 160'(go_n), 160'(5));
        chk("R8", "clears", 160'(clr_n), 160'(5));
        for (int a = 1; a < 5; a++) chk("R5", "timeout gap", 160'(gap[a]), 160'(1));

        // R6 R7 all receive errors
        set_outc(2, 2, 2, 2, 2);
        run_txn(1'b1, 4'h9, 20'h3, 2, '0);
        chk("R7", "rxerr code", 160'(g_code), 160'(3));
        chk("R7", "attempts", 160'(go_n), 160'(5));
        for (int a = 1; a < 5; a++) chk("R6", "backoff gap", 160'(gap[a]), 160'(BO + 1));

        // R5 both flags: timeout wins
        set_outc(3, 0, 0, 0, 0);
        load_rx(3);
        run_txn(1'b1, 4'h9, 20'h4, 2, '0);
        chk("R5", "priority gap", 160'(gap[1]), 160'(1));
        check_reply("R10", 1'b1, 2, 3);

        // R9 bad reply lengths
        set_outc(0, 0, 0, 0, 0);
        load_rx(0);
        run_txn(1'b1, 4'h9, 20'h5, 4, '0);
        check_reply("R9", 1'b1, 4, 0);
        load_rx(21);
        run_txn(1'b1, 4'h9, 20'h5, 4, '0);
        check_reply("R9", 1'b1, 4, 21);

        // random mix
        for (int it = 0; it < 40; it++) begin
            logic rd;
            logic [3:0] c;
            logic [19:0] a;
            int n, nf, rl, sel;
            rd = 1'($urandom % 2);
            n  = rd ? int'($urandom % 20) : int'($urandom % 17);
            c  = 4'($urandom);
            a  = 20'($urandom);
            wd = {$urandom, $urandom, $urandom, $urandom};
            nf = int'($urandom % 3);
            for (int k = 0; k < 8; k++) outc[k] = 0;
            for (int k = 0; k < nf; k++) outc[k] = 1 + int'($urandom % 2);
            sel = int'($urandom % 10);
            if (sel == 0)      rl = 0;
            else if (sel == 1) rl = 21 + int'($urandom % 11);
            else               rl = 1 + int'($urandom % 20);
            for (int b = 0; b < 20; b++) rxb[b] = 8'($urandom);
            load_rx(rl);
            run_txn(rd, c, a, n, wd);
            chk("R1", "rand tx words", first_words, exp_pack(rd, c, a, n, wd));
            chk("R2", "rand tx len", 160'(first_len), 160'(exp_txlen(rd, n)));
            chk("R7", "rand attempts", 160'(go_n), 160'(nf + 1));
            for (int k = 1; k <= nf; k++)
                chk((outc[k-1] == 1) ? "R5" : "R6", "rand gap", 160'(gap[k]),
                    160'((outc[k-1] == 1) ? 1 : BO + 1));
            check_reply(rd ? "R10" : "R11", rd, n, rl);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule